// File: doc/BRIEF.md
# Tiny Byte-Fetch Processor Core

A compact multicycle processor with sixteen 8-bit general registers. Each 16-bit instruction is read as two bytes from consecutive addresses of a synchronous byte-wide memory, then decoded and executed. The instruction set covers register-to-register arithmetic and logic, loading a constant, loading and storing a register at an absolute 8-bit address, and relative branches that are unconditional, taken on carry or taken on zero.

Register 3 is the program counter and also an ordinary register. Any instruction that writes register 3 redirects execution, and a branch simply adds a signed 8-bit offset to it. A debug port reads out any register combinationally so that the core's state can be inspected between instructions.

Instruction layout, from bit 15 down: opcode [15:12], field A [11:8], field B [7:4], field D [3:0]. Fields A and B together form the 8-bit constant or address `K = ir[11:4]`.

Top module: `tiny_core`

## Requirements
- R1: A synchronous reset clears all sixteen registers and both flags, so the first instruction is fetched from address 0x00 with write enable low.
- R2: Each instruction is fetched from the byte at address P (the high byte) and then from P+1 (the low byte), where P is register 3. Register 3 then increases by 2, modulo 256, before the instruction executes. A non-load instruction takes 4 clock cycles and a load takes 5.
- R3: Opcodes 0x0 to 0x5 write register D with A AND B, A OR B, A, NOT B, A+B and A-B respectively. A and B are the registers named by fields A and B, and results are truncated to 8 bits.
- R4: Opcodes 0x0 to 0x5 set the zero flag when the 8-bit result is 0. They set the carry flag to the carry out of bit 7 for add, to 1 exactly when A >= B unsigned for subtract, and to 0 otherwise. No other opcode changes either flag.
- R5: Opcode 0xF writes K into register D.
- R6: Opcode 0x8 writes the memory byte at address K into register D.
- R7: Opcode 0x6 writes register D into memory at address K and leaves every register unchanged.
- R8: Opcode 0xC adds K, read as a signed two's complement value, to register 3 after the fetch increment.
- R9: Opcode 0xE branches like 0xC only when the carry flag is 1. Opcode 0xD does so only when the zero flag is 1. Otherwise they have no effect.
- R10: Opcodes 0x7, 0x9, 0xA and 0xB change nothing apart from the fetch increment.
- R11: The debug output shows the register selected by the debug index in the same cycle.
- R12: Memory write enable is high only during the execute cycle of a store, and exactly once per store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Byte address to memory |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| dbg_sel | input | 4 | Register index for the debug read |
| dbg_data | output | 8 | Contents of the selected register |

## Verification
The bench builds the core with its default parameters: 8-bit data, sixteen registers and register 3 as the program counter. A 256-byte bench memory therefore covers the whole address space. Random programs can branch anywhere, wrap the fetch from 0xFF to 0x00, and overwrite their own code, and the independent reference model follows all of this. A directed program exercises taken and untaken conditional branches, carry from an add, and a zero result from a subtract.

// File: rtl/tiny_core_pkg.sv
package tiny_core_pkg;
    localparam int DW   = 8;
    localparam int NREG = 16;
    localparam int IW   = 16;
    localparam int RIW  = $clog2(NREG);

    typedef enum logic [2:0] {ST_F0, ST_F1, ST_F2, ST_EX, ST_LD} fsm_e;

    localparam logic [3:0] OP_AND  = 4'h0;
    localparam logic [3:0] OP_OR   = 4'h1;
    localparam logic [3:0] OP_PASS = 4'h2;
    localparam logic [3:0] OP_NOTB = 4'h3;
    localparam logic [3:0] OP_ADD  = 4'h4;
    localparam logic [3:0] OP_SUB  = 4'h5;
    localparam logic [3:0] OP_ST   = 4'h6;
    localparam logic [3:0] OP_LD   = 4'h8;
    localparam logic [3:0] OP_JMP  = 4'hC;
    localparam logic [3:0] OP_JZ   = 4'hD;
    localparam logic [3:0] OP_JC   = 4'hE;
    localparam logic [3:0] OP_LI   = 4'hF;

    typedef struct packed {
        logic [3:0]     op;
        logic [RIW-1:0] ra;
        logic [RIW-1:0] rb;
        logic [RIW-1:0] rd;
        logic [DW-1:0]  imm;
    } dec_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          carry;
        logic          zero;
    } alu_out_t;

    typedef struct packed {
        fsm_e                      fsm;
        logic [IW-1:0]             ir;
        logic                      zf;
        logic                      cf;
        logic [NREG-1:0][DW-1:0]   regs;
    } core_st_t;
endpackage

// File: rtl/tiny_decode.sv
module tiny_decode
    import tiny_core_pkg::*;
(
    input  logic [IW-1:0] ir,
    output dec_t          dec
);
    always_comb begin
        dec.op  = ir[15:12];
        dec.ra  = ir[11:8];
        dec.rb  = ir[7:4];
        dec.rd  = ir[3:0];
        dec.imm = ir[11:4];
    end
endmodule

// File: rtl/tiny_alu.sv
module tiny_alu
    import tiny_core_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output alu_out_t      out
);
    logic [DW:0] wide;

    always_comb begin
        unique case (op)
            OP_AND:  wide = {1'b0, a & b};
            OP_OR:   wide = {1'b0, a | b};
            OP_PASS: wide = {1'b0, a};
            OP_NOTB: wide = {1'b0, ~b};
            OP_ADD:  wide = {1'b0, a} + {1'b0, b};
            OP_SUB:  wide = {1'b0, a} - {1'b0, b};
            default: wide = '0;
        endcase
        out.res   = wide[DW-1:0];
        out.carry = (op == OP_SUB) ? ~wide[DW] : wide[DW];
        out.zero  = (wide[DW-1:0] == '0);
    end
endmodule

// File: rtl/tiny_core.sv
module tiny_core
    import tiny_core_pkg::*;
#(
    parameter int PC_REG = 3
) (
    input  logic           clk,
    input  logic           rst,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_we,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [RIW-1:0] dbg_sel,
    output logic [DW-1:0]  dbg_data
);
    localparam logic [DW-1:0] PC_STEP = DW'(IW / 8);

    core_st_t st_q, st_d;
    dec_t     dec;
    alu_out_t alu;
    logic     is_alu_op;
    logic     take_branch;

    tiny_decode u_dec (
        .ir  (st_q.ir),
        .dec (dec)
    );

    tiny_alu u_alu (
        .op  (dec.op),
        .a   (st_q.regs[dec.ra]),
        .b   (st_q.regs[dec.rb]),
        .out (alu)
    );

    assign dbg_data = st_q.regs[dbg_sel];

    always_comb begin
        st_d      = st_q;
        mem_addr  = st_q.regs[PC_REG];
        mem_wdata = st_q.regs[dec.rd];
        mem_we    = 1'b0;
        is_alu_op = (dec.op <= OP_SUB);
        take_branch = (dec.op == OP_JMP) ||
                      (dec.op == OP_JZ && st_q.zf) ||
                      (dec.op == OP_JC && st_q.cf);

        unique case (st_q.fsm)
            ST_F0: begin
                st_d.fsm = ST_F1;
            end
            ST_F1: begin
                mem_addr        = st_q.regs[PC_REG] + DW'(1);
                st_d.ir[15:8]   = mem_rdata;
                st_d.fsm        = ST_F2;
            end
            ST_F2: begin
                st_d.ir[7:0]         = mem_rdata;
                st_d.regs[PC_REG]    = st_q.regs[PC_REG] + PC_STEP;
                st_d.fsm             = ST_EX;
            end
            ST_EX: begin
                st_d.fsm = ST_F0;
                if (is_alu_op) begin
                    st_d.regs[dec.rd] = alu.res;
                    st_d.zf           = alu.zero;
                    st_d.cf           = alu.carry;
                end else if (dec.op == OP_LI) begin
                    st_d.regs[dec.rd] = dec.imm;
                end else if (dec.op == OP_LD) begin
                    mem_addr = dec.imm;
                    st_d.fsm = ST_LD;
                end else if (dec.op == OP_ST) begin
                    mem_addr = dec.imm;
                    mem_we   = 1'b1;
                end else if (take_branch) begin
                    st_d.regs[PC_REG] = st_q.regs[PC_REG] + dec.imm;
                end
            end
            ST_LD: begin
                st_d.regs[dec.rd] = mem_rdata;
                st_d.fsm          = ST_F0;
            end
            default: st_d.fsm = ST_F0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.fsm  <= ST_F0;
            st_q.ir   <= '0;
            st_q.zf   <= 1'b0;
            st_q.cf   <= 1'b0;
            st_q.regs <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tiny_core_chk.sv
module tiny_core_chk
    import tiny_core_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input fsm_e          fsm,
    input logic [IW-1:0] ir,
    input logic [DW-1:0] pc,
    input logic          zf,
    input logic          cf
);
    // R2: low byte address follows the high byte address
    a_r2_fetch_consecutive: assert property (@(posedge clk) disable iff (rst)
        (fsm == ST_F1) |-> (mem_addr == $past(mem_addr) + DW'(1)));

    // R2: counter steps by two when the fetch completes
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (fsm == ST_F2) |=> (pc == $past(pc) + DW'(2)));

    // R12: writes only in the execute cycle of a store
    a_r12_we_only_store: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (fsm == ST_EX && ir[15:12] == OP_ST));

    // R4: flags hold unless an ALU opcode executes
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (fsm != ST_EX || ir[15:12] > OP_SUB) |=> ($stable(zf) && $stable(cf)));

    // R6: the load cycle is followed by a new fetch
    a_r6_load_returns: assert property (@(posedge clk) disable iff (rst)
        (fsm == ST_LD) |=> (fsm == ST_F0));
endmodule

bind tiny_core tiny_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .fsm      (st_q.fsm),
    .ir       (st_q.ir),
    .pc       (st_q.regs[3]),
    .zf       (st_q.zf),
    .cf       (st_q.cf)
);

// File: tb/tiny_core_test.sv
`timescale 1ns/100ps
module tiny_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
    logic       mem_we;
    logic [3:0] dbg_sel = '0;

    int checks = 0;
    int errors = 0;
    int we_seen = 0;
    int st_expected = 0;

    logic [7:0] mem     [256];
    logic [7:0] ref_mem [256];
    logic [7:0] ref_reg [16];
    logic       ref_zf, ref_cf;

    always #4 clk = ~clk;

    tiny_core uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) if (!rst && mem_we) we_seen++;

    task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_reg(input int i, output logic [7:0] v);
        dbg_sel = 4'(i);
        #0.2;
        v = dbg_data;
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5: return "R3";
            4'h6: return "R7";
            4'h8: return "R6";
            4'hC: return "R8";
            4'hD, 4'hE: return "R9";
            4'hF: return "R5";
            default: return "R10";
        endcase
    endfunction

    // Reference ALU per R3 and R4
    task automatic ref_alu(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                           output logic [7:0] r, output logic c);
        int sum;
        c = 1'b0;
        case (op)
            4'h0: r = a & b;
            4'h1: r = a | b;
            4'h2: r = a;
            4'h3: r = ~b;
            4'h4: begin sum = int'(a) + int'(b); r = 8'(sum); c = (sum > 255); end
            default: begin r = a - b; c = (a >= b); end
        endcase
    endtask

    task automatic ref_step(output int cyc, output logic [3:0] op);
        logic [7:0] pc, hi, lo, k, r;
        logic [3:0] fa, fb, fd;
        logic c;
        pc = ref_reg[3];
        hi = ref_mem[pc];
        lo = ref_mem[8'(pc + 8'd1)];
        ref_reg[3] = pc + 8'd2;
        op = hi[7:4]; fa = hi[3:0]; fb = lo[7:4]; fd = lo[3:0];
        k = {fa, fb};
        cyc = 4;
        if (op <= 4'h5) begin
            ref_alu(op, ref_reg[fa], ref_reg[fb], r, c);
            ref_reg[fd] = r;
            ref_zf = (r == 8'h00);
            ref_cf = c;
        end else if (op == 4'hF) ref_reg[fd] = k;
        else if (op == 4'h8) begin ref_reg[fd] = ref_mem[k]; cyc = 5; end
        else if (op == 4'h6) begin ref_mem[k] = ref_reg[fd]; st_expected++; end
        else if (op == 4'hC || (op == 4'hD && ref_zf) || (op == 4'hE && ref_cf))
            ref_reg[3] = ref_reg[3] + k;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 16; i++) ref_reg[i] = 8'h00;
        ref_zf = 1'b0; ref_cf = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state seen at the ports
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            rd_reg(i, v);
            check8("R1", $sformatf("reg%0d after reset", i), v, 8'h00);
        end
        check8("R1", "fetch address after reset", mem_addr, 8'h00);
        check8("R1", "write enable after reset", {7'b0, mem_we}, 8'h00);
        rst = 1'b0;
    endtask

    task automatic run_prog(input int n);
        for (int s = 0; s < n; s++) begin
            int cyc;
            logic [3:0] op;
            ref_step(cyc, op);
            repeat (cyc) @(posedge clk);
            @(negedge clk);
            for (int i = 0; i < 16; i++) begin
                logic [7:0] v;
                rd_reg(i, v);
                // R2 covers reg3 advance; R11 covers debug readout
                check8(req_of(op), $sformatf("step %0d op %h reg%0d", s, op, i), v, ref_reg[i]);
            end
        end
        for (int a = 0; a < 256; a++)
            if (mem[a] !== ref_mem[a]) check8("R7", $sformatf("mem[%0h]", a), mem[a], ref_mem[a]);
        checks++;
        check8("R12", "write strobe count", 8'(we_seen), 8'(st_expected));
    endtask

    task automatic load_both(input int a, input logic [7:0] v);
        mem[a] = v; ref_mem[a] = v;
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int a = 0; a < 256; a++) load_both(a, 8'h00);
        // directed program
        load_both(8'h00, 8'hFF); load_both(8'h01, 8'hE0); // reg0 = -2
        load_both(8'h02, 8'h84); load_both(8'h03, 8'h01); // reg1 = mem[40]
        load_both(8'h04, 8'h40); load_both(8'h05, 8'h12); // reg2 = reg0+reg1
        load_both(8'h06, 8'hE0); load_both(8'h07, 8'h24); // jc +2 (taken)
        load_both(8'h08, 8'hFF); load_both(8'h09, 8'hF5); // skipped
        load_both(8'h0A, 8'h50); load_both(8'h0B, 8'h06); // reg6 = reg0-reg0
        load_both(8'h0C, 8'hD0); load_both(8'h0D, 8'h25); // jz +2 (taken)
        load_both(8'h0E, 8'hFF); load_both(8'h0F, 8'hF7); // skipped
        load_both(8'h10, 8'h70); load_both(8'h11, 8'h00); // unused opcode
        load_both(8'h12, 8'h64); load_both(8'h13, 8'h12); // mem[41] = reg2
        load_both(8'h14, 8'h00); load_both(8'h15, 8'h00); // reg0 &= reg0, flags clear
        load_both(8'h16, 8'hE0); load_both(8'h17, 8'h23); // jc not taken
        load_both(8'h18, 8'hC0); load_both(8'h19, 8'h23); // jmp +2
        load_both(8'h40, 8'h5C);
        do_reset();
        run_prog(11);
        rd_reg(0, v);  check8("R5",  "directed reg0", v, 8'hFE);
        rd_reg(1, v);  check8("R6",  "directed reg1", v, 8'h5C);
        rd_reg(2, v);  check8("R3",  "directed reg2 add", v, 8'h5A);
        rd_reg(5, v);  check8("R9",  "carry branch skipped reg5", v, 8'h00);
        rd_reg(7, v);  check8("R9",  "zero branch skipped reg7", v, 8'h00);
        rd_reg(3, v);  check8("R8",  "directed final pc", v, 8'h1C);
        rd_reg(6, v);  check8("R11", "debug reads reg6", v, 8'h00);
        check8("R7", "directed store", mem[8'h41], 8'h5A);

        // random programs over the whole memory
        for (int round = 0; round < 3; round++) begin
            for (int a = 0; a < 256; a++) load_both(a, 8'($urandom));
            we_seen = 0; st_expected = 0;
            do_reset();
            run_prog(300);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule